// File: doc/BRIEF.md
# Framed Transmit Byte Queue with Space Trigger

This block sits between a host and a transmit serializer of a link controller. The host pushes bytes one at a time. In framed mode each byte also carries a flag that says whether it closes a frame. The queue holds 64 entries, so several whole frames can wait in it at once. On the far side the serializer pulls entries, each with its end-of-frame flag, through a valid/ready handshake. Bit stuffing, flags, CRC and line timing belong to the serializer and are not part of this block.

The host watches a free-space count. A level comparison tells it when enough room has opened up to write a further burst of the programmed size. One-cycle event pulses report three things: a finished frame (or, in transparent mode, a drained queue), a serializer that ran dry in the middle of a frame, and a host abort request that is passed on to the serializer. A synchronous flush input returns the queue to its empty state.

Top module: `txq_framed_fifo`

## Requirements
- R1: After rst_n is released the block shows free_cnt = 64, rd_valid = 0, and tx_done, tx_underrun and ser_abort all at 0.
- R2: Entries leave in the order they were written. Up to 64 entries, covering any number of frames, are held at once. rd_valid is high exactly when at least one entry is stored, and rd_data shows the oldest entry.
- R3: In framed mode (mode_framed = 1) the wr_last value is stored with its byte and comes back on rd_last. In transparent mode (mode_framed = 0) the byte is stored with its flag cleared.
- R4: free_cnt equals 64 minus the number of stored entries. It changes on the clock edge that performs the write or the pop. A pop happens on an edge where rd_valid and rd_ready are both high.
- R5: lvl_hit is high exactly when free_cnt is greater than or equal to the 6-bit trig_lvl.
- R6: In framed mode, popping an entry whose flag is 1 raises tx_done for the single following cycle.
- R7: In transparent mode, tx_done rises for one cycle after a pop that leaves the queue empty with no write on that same edge.
- R8: The block is mid-frame after it pops a framed entry whose flag is 0. It stays mid-frame until a flagged pop, an underrun or an abort. In framed mode, rd_ready high while the queue is empty and mid-frame raises tx_underrun for the next cycle and ends the mid-frame state.
- R9: In framed mode, abort_req raises ser_abort for the next cycle and ends the mid-frame state. In transparent mode abort_req has no effect, and ser_abort stays 0.
- R10: A write while the queue is full and nothing is popped on that edge replaces the newest stored entry, both byte and flag. It raises no signal and leaves free_cnt at 0, so repeated overruns keep landing in that one slot.
- R11: A write and a pop on the same edge leave free_cnt unchanged, even when the queue is full. The written byte is appended after the existing entries.
- R12: tx_flush discards every stored entry, clears the mid-frame state and the event pulses, and takes priority over a write on the same edge. free_cnt reads 64 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_flush | input | 1 | Synchronous transmitter flush |
| mode_framed | input | 1 | 1 = framed mode, 0 = transparent mode |
| trig_lvl | input | 6 | Free-space level for lvl_hit |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host data byte |
| wr_last | input | 1 | Frame-complete flag for this byte |
| abort_req | input | 1 | Request to abort the current frame |
| free_cnt | output | 7 | Number of free entries |
| lvl_hit | output | 1 | Free space has reached trig_lvl |
| tx_done | output | 1 | Frame finished / queue drained pulse |
| tx_underrun | output | 1 | Mid-frame underrun pulse |
| ser_abort | output | 1 | Abort pulse to the serializer |
| rd_valid | output | 1 | Oldest entry available |
| rd_data | output | 8 | Oldest entry byte |
| rd_last | output | 1 | Oldest entry end-of-frame flag |
| rd_ready | input | 1 | Serializer accepts / requests a byte |

## Verification
Writes, pops and flushes change free_cnt, rd_valid, rd_data and rd_last on the same rising edge that performs them. lvl_hit follows combinationally from that count and from trig_lvl. tx_done, tx_underrun and ser_abort come from a register, so each one is visible during the single cycle after the edge where its cause was sampled. The bench drives inputs on the falling edge and advances its queue model on the rising edge. It compares every output on the next falling edge, which puts each sample exactly one edge after its stimulus.

// File: rtl/txq_pkg.sv
package txq_pkg;

   typedef enum logic {
      TXQ_TRANSPARENT = 1'b0,
      TXQ_FRAMED      = 1'b1
   } txq_mode_e;

   typedef struct packed {
      logic done;
      logic underrun;
      logic abort;
   } txq_evt_t;

endpackage

// File: rtl/txq_ptr_ctrl.sv
module txq_ptr_ctrl #(
   parameter  int DEPTH = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic             rd_ready,
   output logic             pop,
   output logic             push,
   output logic             store_we,
   output logic [PTR_W-1:0] store_idx,
   output logic [PTR_W-1:0] head_idx,
   output logic [CNT_W-1:0] count
);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_nxt, rd_nxt, wr_prv;
   logic             full, empty, overwrite;

   // pointer stepping: natural wrap when depth is a power of two
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_prv = wr_ptr - 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_prv = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
      end
   endgenerate

   assign full      = (count == CNT_W'(DEPTH));
   assign empty     = (count == '0);
   assign pop       = rd_ready & ~empty;
   assign push      = wr_en & (~full | pop);
   assign overwrite = wr_en & full & ~pop;
   assign store_we  = ~flush & (push | overwrite);
   assign store_idx = overwrite ? wr_prv : wr_ptr;
   assign head_idx  = rd_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter  int ENT_W = 9,
   parameter  int DEPTH = 64,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] widx,
   input  logic [ENT_W-1:0] wdata,
   input  logic [PTR_W-1:0] ridx,
   output logic [ENT_W-1:0] rdata
);

   logic [ENT_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slots[widx] <= wdata;
   end

   assign rdata = slots[ridx];

endmodule

// File: rtl/txq_evt.sv
module txq_evt
   import txq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     flush,
   input  logic     framed,
   input  logic     abort_req,
   input  logic     rd_ready,
   input  logic     empty,
   input  logic     pop,
   input  logic     push,
   input  logic     head_last,
   input  logic     count_one,
   output txq_evt_t evt
);

   logic     in_frame, in_frame_n;
   txq_evt_t evt_n;

   always_comb begin
      evt_n.underrun = framed & rd_ready & empty & in_frame;
      evt_n.abort    = framed & abort_req;
      evt_n.done     = pop & (framed ? head_last : (count_one & ~push));
      in_frame_n     = pop ? (framed & ~head_last) : in_frame;
      if (evt_n.underrun | evt_n.abort) in_frame_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt      <= '0;
         in_frame <= 1'b0;
      end else if (flush) begin
         evt      <= '0;
         in_frame <= 1'b0;
      end else begin
         evt      <= evt_n;
         in_frame <= in_frame_n;
      end
   end

endmodule

// File: rtl/txq_framed_fifo.sv
module txq_framed_fifo
   import txq_pkg::*;
#(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 64,
   parameter  int LVL_W  = 6,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int ENT_W  = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_flush,
   input  logic              mode_framed,
   input  logic [LVL_W-1:0]  trig_lvl,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic              abort_req,
   output logic [CNT_W-1:0]  free_cnt,
   output logic              lvl_hit,
   output logic              tx_done,
   output logic              tx_underrun,
   output logic              ser_abort,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   input  logic              rd_ready
);

   generate
      if (DEPTH < 2)      begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (DATA_W < 1)     begin : g_bad_width $error("DATA_W must be positive"); end
      if (LVL_W > CNT_W)  begin : g_bad_lvl   $error("LVL_W exceeds count width"); end
   endgenerate

   logic             pop, push, store_we;
   logic [PTR_W-1:0] store_idx, head_idx;
   logic [CNT_W-1:0] count;
   logic [ENT_W-1:0] head_ent;
   txq_evt_t         evt;
   txq_mode_e        mode;

   assign mode = txq_mode_e'(mode_framed);

   txq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .wr_en     (wr_en),
      .rd_ready  (rd_ready),
      .pop       (pop),
      .push      (push),
      .store_we  (store_we),
      .store_idx (store_idx),
      .head_idx  (head_idx),
      .count     (count)
   );

   txq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (store_we),
      .widx  (store_idx),
      .wdata ({wr_last & (mode == TXQ_FRAMED), wr_data}),
      .ridx  (head_idx),
      .rdata (head_ent)
   );

   txq_evt u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .framed    (mode == TXQ_FRAMED),
      .abort_req (abort_req),
      .rd_ready  (rd_ready),
      .empty     (count == '0),
      .pop       (pop),
      .push      (push),
      .head_last (head_ent[ENT_W-1]),
      .count_one (count == CNT_W'(1)),
      .evt       (evt)
   );

   assign free_cnt    = CNT_W'(DEPTH) - count;
   assign lvl_hit     = ({1'b0, free_cnt} >= (CNT_W + 1)'(trig_lvl));
   assign rd_valid    = (count != '0);
   assign rd_data     = head_ent[DATA_W-1:0];
   assign rd_last     = head_ent[ENT_W-1];
   assign tx_done     = evt.done;
   assign tx_underrun = evt.underrun;
   assign ser_abort   = evt.abort;

endmodule

// File: rtl/txq_framed_fifo_chk.sv
module txq_framed_fifo_chk #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 64,
   parameter  int LVL_W  = 6,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_flush,
   input logic              mode_framed,
   input logic [LVL_W-1:0]  trig_lvl,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_last,
   input logic              abort_req,
   input logic [CNT_W-1:0]  free_cnt,
   input logic              lvl_hit,
   input logic              tx_done,
   input logic              tx_underrun,
   input logic              ser_abort,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_last,
   input logic              rd_ready
);

   p_free_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == (free_cnt != CNT_W'(DEPTH)));

   p_done_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_framed && rd_valid && rd_ready && rd_last && !tx_flush) |=> tx_done);

   p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |-> $past(rd_ready && !rd_valid && mode_framed));

   p_abort_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ser_abort |-> $past(abort_req && mode_framed));

   p_full_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (free_cnt == '0 && wr_en && !rd_ready && !tx_flush) |=> (free_cnt == '0));

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && wr_en && !tx_flush) |=> $stable(free_cnt));

   p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (free_cnt == CNT_W'(DEPTH) && !tx_done && !tx_underrun && !ser_abort));

endmodule

bind txq_framed_fifo txq_framed_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/test_txq_framed_fifo.sv
`timescale 1ns/1ps
module test_txq_framed_fifo;

   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n, tx_flush, mode_framed, wr_en, wr_last, abort_req, rd_ready;
   logic [5:0] trig_lvl;
   logic [7:0] wr_data;
   logic [6:0] free_cnt;
   logic       lvl_hit, tx_done, tx_underrun, ser_abort, rd_valid, rd_last;
   logic [7:0] rd_data;

   always #2.5 clk = ~clk;

   txq_framed_fifo i_txq_framed_fifo (
      .clk(clk), .rst_n(rst_n), .tx_flush(tx_flush), .mode_framed(mode_framed),
      .trig_lvl(trig_lvl), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
      .abort_req(abort_req), .free_cnt(free_cnt), .lvl_hit(lvl_hit),
      .tx_done(tx_done), .tx_underrun(tx_underrun), .ser_abort(ser_abort),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .rd_ready(rd_ready)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string phase = "reset";

   // behavioural reference
   logic [8:0] q[$];
   bit m_inframe, m_done, m_und, m_ab;

   always @(posedge clk or negedge rst_n) begin
      int sz;
      bit pop, lastb;
      if (!rst_n) begin
         q.delete(); m_inframe = 0; m_done = 0; m_und = 0; m_ab = 0;
      end else if (tx_flush) begin
         q.delete(); m_inframe = 0; m_done = 0; m_und = 0; m_ab = 0;
      end else begin
         sz    = q.size();
         pop   = rd_ready && sz != 0;
         lastb = pop ? q[0][8] : 1'b0;
         m_und = mode_framed && rd_ready && sz == 0 && m_inframe;
         m_ab  = mode_framed && abort_req;
         m_done = pop && (mode_framed ? lastb : (sz == 1 && !wr_en));
         if (pop) begin
            void'(q.pop_front());
            m_inframe = mode_framed && !lastb;
         end
         if (m_und || m_ab) m_inframe = 0;
         if (wr_en) begin
            if (q.size() == DEPTH) q[DEPTH-1] = {wr_last & mode_framed, wr_data};
            else q.push_back({wr_last & mode_framed, wr_data});
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] at %0t: actual %0h expected %0h", what, phase, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 free count", free_cnt, DEPTH - q.size());
         chk("R5 level hit", lvl_hit, (DEPTH - q.size()) >= trig_lvl);
         chk("R2 valid", rd_valid, q.size() != 0);
         if (q.size() != 0) begin
            chk("R2 head byte", rd_data, q[0][7:0]);
            chk("R3 head flag", rd_last, q[0][8]);
         end
         chk("R6 R7 done", tx_done, m_done);
         chk("R8 underrun", tx_underrun, m_und);
         chk("R9 abort", ser_abort, m_ab);
      end
   end

   task automatic cyc(input bit we, input logic [7:0] d, input bit l, input bit rdy,
                      input bit ab, input bit fl);
      @(negedge clk);
      wr_en = we; wr_data = d; wr_last = l; rd_ready = rdy; abort_req = ab; tx_flush = fl;
   endtask

   task automatic idle(input bit rdy, input int n);
      for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, rdy, 0, 0);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      rst_n = 0; tx_flush = 0; mode_framed = 1; wr_en = 0; wr_last = 0;
      abort_req = 0; rd_ready = 0; wr_data = 0; trig_lvl = 6'd16;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 free after reset", free_cnt, 64);
      chk("R1 valid after reset", rd_valid, 0);
      chk("R1 events after reset", {tx_done, tx_underrun, ser_abort}, 0);

      // two frames, held and then drained
      phase = "R2 R3 R6 frames";
      cyc(1, 8'h11, 0, 0, 0, 0); cyc(1, 8'h12, 0, 0, 0, 0); cyc(1, 8'h13, 1, 0, 0, 0);
      cyc(1, 8'h21, 0, 0, 0, 0); cyc(1, 8'h22, 1, 0, 0, 0);
      idle(0, 1);
      phase = "R5 level";
      trig_lvl = 6'd59; idle(0, 1);
      chk("R5 level equal", lvl_hit, 1);
      trig_lvl = 6'd60; idle(0, 1);
      chk("R5 level above", lvl_hit, 0);
      trig_lvl = 6'd0; idle(0, 1);
      phase = "R6 drain";
      idle(1, 8);

      // underrun mid-frame
      phase = "R8 underrun";
      cyc(1, 8'h31, 0, 0, 0, 0); cyc(1, 8'h32, 0, 0, 0, 0);
      idle(1, 5);
      idle(0, 1);

      // abort in framed mode clears mid-frame
      phase = "R9 framed abort";
      cyc(1, 8'h41, 0, 1, 0, 0);
      idle(1, 1);
      cyc(0, 8'h00, 0, 0, 1, 0);
      idle(1, 4);

      // fill, overrun, simultaneous access
      phase = "R10 overrun";
      trig_lvl = 6'd1;
      for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i), 0, 0, 0, 0);
      cyc(1, 8'hA1, 0, 0, 0, 0); cyc(1, 8'hA2, 0, 0, 0, 0); cyc(1, 8'hA3, 1, 0, 0, 0);
      idle(0, 1);
      chk("R10 full stays full", free_cnt, 0);
      chk("R10 head untouched", rd_data, 8'h00);
      phase = "R11 simultaneous";
      cyc(1, 8'hB0, 1, 1, 0, 0);
      idle(0, 1);
      chk("R11 count unchanged", free_cnt, 0);
      phase = "R10 R11 drain";
      idle(1, 70);

      // transparent mode
      phase = "R3 R7 R9 transparent";
      mode_framed = 0;
      cyc(1, 8'h51, 1, 0, 0, 0); cyc(1, 8'h52, 1, 0, 0, 0); cyc(1, 8'h53, 0, 0, 1, 0);
      idle(0, 1);
      chk("R9 transparent abort ignored", ser_abort, 0);
      chk("R3 transparent flag cleared", rd_last, 0);
      idle(1, 5);
      cyc(1, 8'h61, 0, 1, 0, 0); cyc(1, 8'h62, 0, 1, 0, 0);
      idle(1, 3);

      // flush with a concurrent write
      phase = "R12 flush";
      mode_framed = 1;
      for (int i = 0; i < 5; i++) cyc(1, 8'(8'h70 + i), 0, 0, 0, 0);
      cyc(1, 8'h7F, 1, 0, 0, 1);
      idle(0, 1);
      chk("R12 flush empties", free_cnt, 64);
      chk("R12 flush drops write", rd_valid, 0);
      idle(1, 2);

      // mixed traffic
      phase = "mixed R2 R4 R5 R8";
      for (int i = 0; i < 3000; i++) begin
         if (i % 500 == 0) mode_framed = ~mode_framed;
         if (i % 37 == 0) trig_lvl = 6'($urandom);
         cyc(($urandom % 3) != 0, 8'($urandom), ($urandom % 4) == 0,
             ($urandom % 2) == 0, ($urandom % 41) == 0, ($urandom % 211) == 0);
      end
      idle(1, 80);
      summary();
   end

endmodule